// File: doc/BRIEF.md
# UART Line Break Monitor

This block watches the receive line of a UART. It finds break conditions, where the line stays at logic low for at least one whole character time, stop-bit position included. For each break it measures the duration in whole characters and keeps a count of separate break events. The block samples the line only on a bit-rate strobe from an external baud generator. The character length comes from a configuration input and is forced into the range 7 to 13 bit times.

Software reads two saturating registers. The first holds the length of the most recent break. The second holds the number of breaks seen. Each register has its own clear input. Two one-cycle pulses mark the start of a break, when it is declared, and its end, when the line returns high. A level output shows that a break is in progress. The block does not include the data receiver or any buffer handling.

Top module: `uart_break_monitor`

## Requirements
- R1: After a synchronous active-low reset, `brk_len`, `brk_cnt`, `brk_start`, `brk_end` and `in_break` are all zero.
- R2: A break is declared when `rxd` has been sampled low on `clen` consecutive `bit_tick` strobes, where `clen` is the effective character length. A low run shorter than `clen` strobes changes neither register and gives no pulse.
- R3: When a break is declared, `brk_start` pulses high for exactly one cycle. `brk_cnt` then rises by exactly one, however long the line stays low.
- R4: When `rxd` is sampled high at a strobe during a break, the break ends. `brk_end` pulses for one cycle, and `brk_len` then takes the value floor(low strobes / `clen`), which is never zero.
- R5: The effective character length is `char_bits` when 7 <= `char_bits` <= 13. It is 7 when `char_bits` is below 7 and 13 when `char_bits` is above 13.
- R6: `brk_cnt` and `brk_len` saturate at the all-ones value of `CNT_W` bits and never wrap.
- R7: `clr_len` zeroes `brk_len`, and `clr_cnt` zeroes `brk_cnt`. If a clear arrives in the same cycle as an update, the update wins: `brk_len` takes the new length, and `brk_cnt` becomes 1.
- R8: `rxd` is ignored in cycles where `bit_tick` is low. A low level between strobes neither starts nor extends a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Receive line, already synchronised to clk |
| bit_tick | input | 1 | One-cycle strobe per bit time; the line is sampled here |
| char_bits | input | 4 | Character length in bit times (clamped to 7..13) |
| clr_len | input | 1 | Clear the last-break-length register |
| clr_cnt | input | 1 | Clear the break event counter |
| brk_len | output | CNT_W | Length of the last completed break, in characters |
| brk_cnt | output | CNT_W | Number of breaks detected |
| brk_start | output | 1 | One-cycle pulse when a break is declared |
| brk_end | output | 1 | One-cycle pulse when a break finishes |
| in_break | output | 1 | High while a break is in progress |

## Verification
The embedded assertions check, on every cycle, the following properties: both pulses last one cycle and never coincide; the counter moves by at most one step and only on a start pulse or a clear; the length register holds its value unless an end pulse or a clear occurs; the character counter stays at its limit once saturated; and the bit counter stays below the longest character. Only the bench scenarios can show that the arithmetic is right. These scenarios cover length quantisation for each character size, clamping of configuration values outside the range, glitches between strobes being ignored, register saturation in a narrow instance, and an update winning over a clear in the same cycle.

// File: rtl/brk_pkg.sv
// Shared constants and helpers for the UART line break monitor.
// Assumes a character length field of 4 bits.
package brk_pkg;
    localparam int BIT_W    = 4;
    localparam int MIN_CHAR = 7;
    localparam int MAX_CHAR = 13;

    // Force a requested character length into the supported range.
    function automatic logic [BIT_W-1:0] clamp_len(input logic [BIT_W-1:0] req);
        if (req < BIT_W'(MIN_CHAR))      return BIT_W'(MIN_CHAR);
        else if (req > BIT_W'(MAX_CHAR)) return BIT_W'(MAX_CHAR);
        else                             return req;
    endfunction
endpackage

// File: rtl/brk_bit_timer.sv
// Counts consecutive low samples of the line, taken at bit strobes, and
// raises char_done each time a full character time of low has gone by.
// Assumes rxd is already synchronised and clen lies within 7..13.
module brk_bit_timer
    import brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             bit_tick,
    input  logic [BIT_W-1:0] clen,
    output logic             char_done,
    output logic             line_high
);
    logic [BIT_W-1:0] bitcnt;

    // A character of low is complete when this strobe fills the count.
    assign char_done = bit_tick && !rxd && ((bitcnt + BIT_W'(1)) >= clen);
    assign line_high = bit_tick && rxd;

    // Advance the low-bit count on low strobes and restart it on high or on a full character.
    always_ff @(posedge clk) begin
        if (!rst_n)                  bitcnt <= '0;
        else if (bit_tick) begin
            if (rxd || char_done)    bitcnt <= '0;
            else                     bitcnt <= bitcnt + BIT_W'(1);
        end
    end

    assert_bitcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt < BIT_W'(MAX_CHAR));

    assert_ignore_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(bitcnt));
endmodule

// File: rtl/brk_tracker.sv
// Break state machine. It declares a break on the first full character of
// low and counts further characters while the line stays low, saturating
// at the top of CNT_W. The break ends at the first high strobe.
// Assumes char_done and line_high are never high together.
module brk_tracker #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_done,
    input  logic             line_high,
    output logic             in_break,
    output logic [CNT_W-1:0] chars,
    output logic             brk_start,
    output logic             brk_end
);
    localparam logic [CNT_W-1:0] CHARS_MAX = '1;

    // Track break state, count the characters of the break and emit the start and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_break  <= 1'b0;
            chars     <= '0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (char_done) begin
                if (!in_break) begin
                    in_break  <= 1'b1;
                    chars     <= CNT_W'(1);
                    brk_start <= 1'b1;
                end else if (chars != CHARS_MAX) begin
                    chars <= chars + CNT_W'(1);
                end
            end else if (line_high && in_break) begin
                in_break <= 1'b0;
                brk_end  <= 1'b1;
            end
        end
    end

    assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> !brk_start);

    assert_end_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |=> !brk_end);

    assert_no_start_end_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_start && brk_end));

    assert_start_enters_break_R2: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |-> in_break);

    assert_chars_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_break && chars == CHARS_MAX) |=> (chars == CHARS_MAX));
endmodule

// File: rtl/brk_regs.sv
// Registers that software reads: the length of the last break and the
// break event counter. Both saturate, and an update takes priority over a
// clear arriving in the same cycle.
// Assumes brk_start and brk_end are single-cycle pulses.
module brk_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             brk_start,
    input  logic             brk_end,
    input  logic [CNT_W-1:0] chars,
    input  logic             clr_len,
    input  logic             clr_cnt,
    output logic [CNT_W-1:0] brk_len,
    output logic [CNT_W-1:0] brk_cnt
);
    localparam logic [CNT_W-1:0] REG_MAX = '1;

    // Count break events, saturating; a clear in the same cycle leaves only the new event.
    always_ff @(posedge clk) begin
        if (!rst_n)                  brk_cnt <= '0;
        else if (brk_start) begin
            if (clr_cnt)             brk_cnt <= CNT_W'(1);
            else if (brk_cnt != REG_MAX) brk_cnt <= brk_cnt + CNT_W'(1);
        end else if (clr_cnt)        brk_cnt <= '0;
    end

    // Latch the finished break's length in characters, or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  brk_len <= '0;
        else if (brk_end)            brk_len <= chars;
        else if (clr_len)            brk_len <= '0;
    end

    assert_cnt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_start && !clr_cnt) |=> $stable(brk_cnt));

    assert_cnt_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cnt |=> (brk_cnt == $past(brk_cnt) || brk_cnt == $past(brk_cnt) + CNT_W'(1)));

    assert_cnt_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_cnt == REG_MAX && !clr_cnt) |=> (brk_cnt == REG_MAX));

    assert_len_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_end && !clr_len) |=> $stable(brk_len));

    assert_len_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |=> (brk_len != '0));

    assert_clear_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_len && !brk_end) |=> (brk_len == '0));
endmodule

// File: rtl/uart_break_monitor.sv
// Top level of the UART line break monitor. It clamps the configured
// character length, times low runs at bit strobes, follows break state and
// holds the registers that software reads.
// Assumes rxd is synchronised to clk and bit_tick is one cycle per bit time.
module uart_break_monitor
    import brk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             bit_tick,
    input  logic [3:0]       char_bits,
    input  logic             clr_len,
    input  logic             clr_cnt,
    output logic [CNT_W-1:0] brk_len,
    output logic [CNT_W-1:0] brk_cnt,
    output logic             brk_start,
    output logic             brk_end,
    output logic             in_break
);
    logic [BIT_W-1:0] clen;
    logic             char_done;
    logic             line_high;
    logic [CNT_W-1:0] chars;

    // Effective character length after clamping.
    always_comb clen = clamp_len(char_bits);

    brk_bit_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .bit_tick  (bit_tick),
        .clen      (clen),
        .char_done (char_done),
        .line_high (line_high)
    );

    brk_tracker #(.CNT_W(CNT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (char_done),
        .line_high (line_high),
        .in_break  (in_break),
        .chars     (chars),
        .brk_start (brk_start),
        .brk_end   (brk_end)
    );

    brk_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_start (brk_start),
        .brk_end   (brk_end),
        .chars     (chars),
        .clr_len   (clr_len),
        .clr_cnt   (clr_cnt),
        .brk_len   (brk_len),
        .brk_cnt   (brk_cnt)
    );

    assert_clen_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clen >= BIT_W'(MIN_CHAR) && clen <= BIT_W'(MAX_CHAR));
endmodule

// File: tb/sim_uart_break_monitor.sv
module sim_uart_break_monitor;
    localparam int NW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic bit_tick = 1'b0;
    logic [3:0] char_bits = 4'd10;
    logic man_clr_len = 1'b0;
    logic man_clr_cnt = 1'b0;
    logic arm_len = 1'b0;
    logic arm_cnt = 1'b0;
    logic clr_len, clr_cnt;

    logic [15:0] len0, cnt0;
    logic [NW-1:0] len1, cnt1;
    logic st0, en0, ib0, st1, en1, ib1;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int n_end = 0;
    int exp_cnt0 = 0, exp_len0 = 0, exp_cnt1 = 0, exp_len1 = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign clr_cnt = man_clr_cnt | (arm_cnt & st0);
    assign clr_len = man_clr_len | (arm_len & en0);

    uart_break_monitor u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_tick(bit_tick), .char_bits(char_bits),
        .clr_len(clr_len), .clr_cnt(clr_cnt), .brk_len(len0), .brk_cnt(cnt0),
        .brk_start(st0), .brk_end(en0), .in_break(ib0));

    uart_break_monitor #(.CNT_W(NW)) u1 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_tick(bit_tick), .char_bits(char_bits),
        .clr_len(clr_len), .clr_cnt(clr_cnt), .brk_len(len1), .brk_cnt(cnt1),
        .brk_start(st1), .brk_end(en1), .in_break(ib1));

    // Count the pulses of u0 away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (st0) n_start++;
            if (en0) n_end++;
        end
    end

    function automatic int eff_len(input int cfg);
        if (cfg < 7) return 7;
        if (cfg > 13) return 13;
        return cfg;
    endfunction

    function automatic int sat(input int v, input int maxv);
        return (v > maxv) ? maxv : v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Hold the line low for n strobes, release it, and update the model.
    task automatic send_low(input int n);
        int cl;
        cl = eff_len(int'(char_bits));
        for (int i = 0; i < n; i++) begin
            rxd = 1'b0;
            tick();
        end
        rxd = 1'b1;
        tick();
        tick();
        repeat (3) @(negedge clk);
        if (n >= cl) begin
            exp_cnt0 = sat(exp_cnt0 + 1, 65535);
            exp_len0 = sat(n / cl, 65535);
            exp_cnt1 = sat(exp_cnt1 + 1, (1 << NW) - 1);
            exp_len1 = sat(n / cl, (1 << NW) - 1);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " cnt"}, int'(cnt0), exp_cnt0);
        chk({tag, " len"}, int'(len0), exp_len0);
        chk({tag, " starts"}, n_start, exp_cnt0 > 0 ? n_start : 0);
        chk({tag, " in_break"}, int'(ib0), 0);
    endtask

    initial begin
        int seedv;
        seedv = $urandom(32'd2024);
        repeat (5) @(negedge clk);
        // R1: reset values
        chk("R1 len", int'(len0), 0);
        chk("R1 cnt", int'(cnt0), 0);
        chk("R1 pulses", int'(st0) + int'(en0) + int'(ib0), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: 20 low bits with a 10-bit character give a length of 2
        char_bits = 4'd10;
        send_low(20);
        chk("R4 len 20/10", int'(len0), 2);
        chk("R3 cnt first", int'(cnt0), 1);
        chk("R4 end pulses", n_end, 1);

        // R2: 9 low bits are not a break
        send_low(9);
        chk("R2 short cnt", int'(cnt0), 1);
        chk("R2 short len", int'(len0), 2);
        chk("R2 no start", n_start, 1);

        // R3: a very long break is counted once
        send_low(300);
        chk("R3 long cnt", int'(cnt0), 2);
        chk("R3 long starts", n_start, 2);
        chk("R4 long len", int'(len0), 30);

        // R8: low between strobes is ignored
        for (int i = 0; i < 15; i++) begin
            rxd = 1'b1;
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            rxd = 1'b0;
            repeat (2) @(negedge clk);
            rxd = 1'b1;
            @(negedge clk);
        end
        chk("R8 glitch cnt", int'(cnt0), 2);
        chk("R8 glitch in_break", int'(ib0), 0);
        chk("R8 glitch starts", n_start, 2);

        // R5: clamping of the character length
        char_bits = 4'd3;
        send_low(7);
        chk("R5 low cfg cnt", int'(cnt0), exp_cnt0);
        chk("R5 low cfg len", int'(len0), 1);
        char_bits = 4'd0;
        send_low(6);
        chk("R5 low cfg short", int'(cnt0), exp_cnt0);
        char_bits = 4'd15;
        send_low(25);
        chk("R5 high cfg len25", int'(len0), 1);
        send_low(26);
        chk("R5 high cfg len26", int'(len0), 2);
        send_low(12);
        chk("R5 high cfg short", int'(cnt0), exp_cnt0);

        // R7: plain clears
        man_clr_len = 1'b1;
        @(negedge clk);
        man_clr_len = 1'b0;
        @(negedge clk);
        chk("R7 clear len", int'(len0), 0);
        man_clr_cnt = 1'b1;
        @(negedge clk);
        man_clr_cnt = 1'b0;
        @(negedge clk);
        chk("R7 clear cnt", int'(cnt0), 0);
        exp_len0 = 0; exp_cnt0 = 0; exp_len1 = 0; exp_cnt1 = 0;

        // R7: an update wins over a clear in the same cycle
        char_bits = 4'd8;
        send_low(8);
        send_low(8);
        arm_cnt = 1'b1;
        arm_len = 1'b1;
        send_low(24);
        arm_cnt = 1'b0;
        arm_len = 1'b0;
        chk("R7 cnt update wins", int'(cnt0), 1);
        chk("R7 len update wins", int'(len0), 3);
        exp_cnt0 = 1; exp_cnt1 = 1;

        // R6: saturation in the narrow instance
        man_clr_cnt = 1'b1;
        man_clr_len = 1'b1;
        @(negedge clk);
        man_clr_cnt = 1'b0;
        man_clr_len = 1'b0;
        exp_cnt0 = 0; exp_cnt1 = 0; exp_len0 = 0; exp_len1 = 0;
        char_bits = 4'd7;
        for (int i = 0; i < 9; i++) send_low(7);
        chk("R6 narrow cnt sat", int'(cnt1), 7);
        chk("R6 wide cnt", int'(cnt0), 9);
        send_low(70);
        chk("R6 narrow len sat", int'(len1), 7);
        chk("R6 wide len", int'(len0), 10);

        // R2 R4 R5: random lengths and configurations
        for (int k = 0; k < 25; k++) begin
            int s0;
            int n;
            s0 = n_start;
            char_bits = 4'($urandom_range(0, 15));
            n = $urandom_range(1, 45);
            send_low(n);
            chk("R4 rand len", int'(len0), exp_len0);
            chk("R3 rand cnt", int'(cnt0), exp_cnt0);
            chk("R6 rand narrow cnt", int'(cnt1), exp_cnt1);
            chk("R2 rand start", n_start - s0, (n >= eff_len(int'(char_bits))) ? 1 : 0);
            chk("R4 rand ends", n_end, n_start);
        end
        check_all("final");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule